// File: doc/BRIEF.md
# Debug Telemetry Frame Serializer

This block is a transmit-only synchronous serial port for a capacitive touch controller's debug mode. When debug mode is enabled and the acquisition engine pulses a frame start strobe, the block captures a complete snapshot of the engine's state and sends it as a fixed 30-byte frame. The frame goes out on a clock line and a data line, with the most significant bit of each byte first. The frame carries a frame counter, a version byte, four 16-bit reference levels, four 16-bit signal levels, four signed 16-bit deltas, two flag bytes and a packed status byte. The frame counter is repeated at the end of the frame.

Bytes start on a fixed slot grid. Each byte's eight clock pulses are followed by a quiet gap, and the next byte starts exactly one slot after the previous one. The line-enable output is high only while a frame is in flight. Outside a frame, the pad ring places both lines in high impedance. While the lines are driven, the clock rests low, and data changes only while the clock is low.

A state machine sequences each frame through five states. IDLE waits, with the lines released. LOAD hands the next byte to the shifter. SHIFT waits while the shifter produces eight clock pulses. GAP pads the rest of the byte slot. FINISH advances the frame counter and returns to IDLE. The transitions are:
- IDLE→LOAD on an accepted start.
- LOAD→SHIFT always.
- SHIFT→GAP when the shifter finishes a byte that is not the last one.
- SHIFT→FINISH when it finishes the last byte.
- GAP→LOAD at the end of the slot.
- FINISH→IDLE always.

Top module: `dbg_frame_tx`

## Requirements
- R1: After reset, `ser_oe` and `ser_clk` are low, and `ser_oe` stays low whenever no frame is being sent.
- R2: Byte 0 and byte 29 both carry the frame number. The frame number is 0 for the first frame after reset, rises by one for each completed frame, and wraps from 255 to 0.
- R3: Byte 1 is `version_i` as captured at the start (major revision in bits 7:4, minor revision in bits 3:0).
- R4: Bytes 2–9 carry the references of channels 0 to 3, bytes 10–17 the signals and bytes 18–25 the deltas (two's complement). Channel k takes bits [16k+15:16k] of its input bus, and each value is sent low byte first.
- R5: Byte 26 is `flag0_i` and byte 27 is `flag1_i`. Byte 28 is the status byte, with `cal_i` in bit 7, `nact_i` in bits 6:4 and `touch_i` in bits 3:0.
- R6: Bits go out MSB first, sampled on the rising edge of `ser_clk`. Each clock phase lasts HALF_BIT cycles, and each byte's first rising edge comes exactly BYTE_SLOT cycles after that of the previous byte.
- R7: While `ser_clk` is high, `ser_dat` does not change. `ser_clk` is low whenever no bit is being clocked, including when the lines are released.
- R8: All fields are captured in the cycle that the start is accepted. Input changes during a frame do not alter that frame.
- R9: A start pulse that arrives while a frame is in progress is ignored. It neither restarts the frame nor produces an extra frame or counter step.
- R10: A start pulse while `dbg_en` is low is ignored. The lines stay released and the frame number does not advance.
- R11: A frame is exactly 30 bytes. `ser_oe` stays high for 29·BYTE_SLOT + 16·HALF_BIT + 2 cycles and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_en | input | 1 | Debug mode active; gates frame starts |
| start | input | 1 | Frame start strobe from the acquisition engine |
| version_i | input | 8 | Revision byte (major in 7:4, minor in 3:0) |
| ref_i | input | 64 | Four unsigned 16-bit references, channel k at [16k+15:16k] |
| sig_i | input | 64 | Four unsigned 16-bit signals, same packing |
| dlt_i | input | 64 | Four signed 16-bit deltas, same packing |
| flag0_i | input | 8 | First flag byte |
| flag1_i | input | 8 | Second flag byte |
| cal_i | input | 1 | Calibration in progress |
| nact_i | input | 3 | Count of active keys |
| touch_i | input | 4 | Per-key touch status |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_dat | output | 1 | Serial data, valid on rising ser_clk |
| ser_oe | output | 1 | Line drive enable; low means both lines released |

## Verification
The assertions check four timing properties on every cycle:
- data holds steady across each high clock phase, and the clock is low whenever the lines are released;
- every byte after the first loads exactly one slot after the previous one;
- a frame never returns to IDLE before its last byte;
- the frame number steps by one at each FINISH.

Only the bench scenarios can show that each of the 30 byte positions carries the right field with the right byte order. The same holds for three input-handling properties: snapshots ignore mid-frame input changes, starts that are busy or disabled leave no trace, and the counter wraps through 255.

// File: rtl/dft_pkg.sv
package dft_pkg;

    localparam int NUM_KEYS    = 4;
    localparam int VAL_W       = 16;
    localparam int KEY_W       = $clog2(NUM_KEYS);
    localparam int REF_BASE    = 2;
    localparam int SIG_BASE    = REF_BASE + 2 * NUM_KEYS;
    localparam int DLT_BASE    = SIG_BASE + 2 * NUM_KEYS;
    localparam int FLG_BASE    = DLT_BASE + 2 * NUM_KEYS;
    localparam int STAT_IDX    = FLG_BASE + 2;
    localparam int FRAME_BYTES = STAT_IDX + 2;
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_SHIFT,
        S_GAP,
        S_FINISH
    } tx_state_e;

    function automatic logic [7:0] pick_half(input logic [VAL_W-1:0] w, input logic hi);
        return hi ? w[15:8] : w[7:0];
    endfunction

endpackage

// File: rtl/dft_frame_store.sv
module dft_frame_store
    import dft_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap,
    input  logic [7:0]                fnum_i,
    input  logic [7:0]                version_i,
    input  logic [NUM_KEYS*VAL_W-1:0] ref_i,
    input  logic [NUM_KEYS*VAL_W-1:0] sig_i,
    input  logic [NUM_KEYS*VAL_W-1:0] dlt_i,
    input  logic [7:0]                flag0_i,
    input  logic [7:0]                flag1_i,
    input  logic [7:0]                status_i,
    input  logic [IDX_W-1:0]          idx_i,
    output logic [7:0]                byte_o
);

    logic [7:0]       fnum_q, ver_q, fl0_q, fl1_q, stat_q;
    logic [VAL_W-1:0] ref_q [NUM_KEYS];
    logic [VAL_W-1:0] sig_q [NUM_KEYS];
    logic [VAL_W-1:0] dlt_q [NUM_KEYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fnum_q <= '0;
            ver_q  <= '0;
            fl0_q  <= '0;
            fl1_q  <= '0;
            stat_q <= '0;
        end else if (cap) begin
            fnum_q <= fnum_i;
            ver_q  <= version_i;
            fl0_q  <= flag0_i;
            fl1_q  <= flag1_i;
            stat_q <= status_i;
        end
    end

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ref_q[k] <= '0;
                sig_q[k] <= '0;
                dlt_q[k] <= '0;
            end else if (cap) begin
                ref_q[k] <= ref_i[k*VAL_W +: VAL_W];
                sig_q[k] <= sig_i[k*VAL_W +: VAL_W];
                dlt_q[k] <= dlt_i[k*VAL_W +: VAL_W];
            end
        end
    end

    logic [IDX_W-1:0] off;

    always_comb begin
        byte_o = fnum_q;
        off    = '0;
        if (idx_i == IDX_W'(1)) begin
            byte_o = ver_q;
        end else if (idx_i >= IDX_W'(REF_BASE) && idx_i < IDX_W'(SIG_BASE)) begin
            off    = idx_i - IDX_W'(REF_BASE);
            byte_o = pick_half(ref_q[off[KEY_W:1]], off[0]);
        end else if (idx_i >= IDX_W'(SIG_BASE) && idx_i < IDX_W'(DLT_BASE)) begin
            off    = idx_i - IDX_W'(SIG_BASE);
            byte_o = pick_half(sig_q[off[KEY_W:1]], off[0]);
        end else if (idx_i >= IDX_W'(DLT_BASE) && idx_i < IDX_W'(FLG_BASE)) begin
            off    = idx_i - IDX_W'(DLT_BASE);
            byte_o = pick_half(dlt_q[off[KEY_W:1]], off[0]);
        end else if (idx_i == IDX_W'(FLG_BASE)) begin
            byte_o = fl0_q;
        end else if (idx_i == IDX_W'(FLG_BASE + 1)) begin
            byte_o = fl1_q;
        end else if (idx_i == IDX_W'(STAT_IDX)) begin
            byte_o = stat_q;
        end
    end

endmodule

// File: rtl/dft_byte_shifter.sv
module dft_byte_shifter #(
    parameter int HALF_BIT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] byte_i,
    output logic       done,
    output logic       sclk,
    output logic       sdat
);

    localparam int HB_W = $clog2(HALF_BIT + 1);

    logic [7:0]      sh_q;
    logic [2:0]      bit_q;
    logic [HB_W-1:0] hcnt_q;
    logic            clk_q, act_q;
    logic            half_end;

    assign half_end = (hcnt_q == HB_W'(HALF_BIT - 1));
    assign done     = act_q && clk_q && half_end && (bit_q == 3'd7);
    assign sclk     = clk_q;
    assign sdat     = sh_q[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bit_q  <= '0;
            hcnt_q <= '0;
            clk_q  <= 1'b0;
            act_q  <= 1'b0;
        end else if (load) begin
            sh_q   <= byte_i;
            bit_q  <= '0;
            hcnt_q <= '0;
            clk_q  <= 1'b0;
            act_q  <= 1'b1;
        end else if (act_q) begin
            if (half_end) begin
                hcnt_q <= '0;
                if (!clk_q) begin
                    clk_q <= 1'b1;
                end else begin
                    clk_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        act_q <= 1'b0;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                hcnt_q <= hcnt_q + HB_W'(1);
            end
        end
    end

    AST_DAT_STABLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_q && $past(clk_q)) |-> $stable(sdat)) else $error("data moved while clock high"); // R7

    AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> !clk_q) else $error("clock high outside a byte"); // R7

endmodule

// File: rtl/dbg_frame_tx.sv
module dbg_frame_tx
    import dft_pkg::*;
#(
    parameter int HALF_BIT  = 4,
    parameter int BYTE_SLOT = 96
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dbg_en,
    input  logic        start,
    input  logic [7:0]  version_i,
    input  logic [63:0] ref_i,
    input  logic [63:0] sig_i,
    input  logic [63:0] dlt_i,
    input  logic [7:0]  flag0_i,
    input  logic [7:0]  flag1_i,
    input  logic        cal_i,
    input  logic [2:0]  nact_i,
    input  logic [3:0]  touch_i,
    output logic        ser_clk,
    output logic        ser_dat,
    output logic        ser_oe
);

    localparam int SLOT_W = $clog2(BYTE_SLOT + 1);

    tx_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [SLOT_W-1:0] slot_q;
    logic [7:0]       fnum_q;
    logic             accept, sh_load, sh_done, last_byte, slot_end;
    logic [7:0]       cur_byte;

    assign accept    = (state_q == S_IDLE) && start && dbg_en;
    assign last_byte = (idx_q == IDX_W'(FRAME_BYTES - 1));
    assign slot_end  = (slot_q == SLOT_W'(BYTE_SLOT - 2));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_LOAD;
            S_LOAD:   state_d = S_SHIFT;
            S_SHIFT:  if (sh_done) state_d = last_byte ? S_FINISH : S_GAP;
            S_GAP:    if (slot_end) state_d = S_LOAD;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        ser_oe  = (state_q != S_IDLE);
        sh_load = (state_q == S_LOAD);
    end

    // byte index, slot timer, frame counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            slot_q <= '0;
            fnum_q <= '0;
        end else begin
            if (accept)
                idx_q <= '0;
            else if (state_q == S_GAP && slot_end)
                idx_q <= idx_q + IDX_W'(1);
            if (state_q == S_IDLE || state_q == S_LOAD)
                slot_q <= '0;
            else
                slot_q <= slot_q + SLOT_W'(1);
            if (state_q == S_FINISH)
                fnum_q <= fnum_q + 8'd1;
        end
    end

    dft_frame_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (accept),
        .fnum_i    (fnum_q),
        .version_i (version_i),
        .ref_i     (ref_i),
        .sig_i     (sig_i),
        .dlt_i     (dlt_i),
        .flag0_i   (flag0_i),
        .flag1_i   (flag1_i),
        .status_i  ({cal_i, nact_i, touch_i}),
        .idx_i     (idx_q),
        .byte_o    (cur_byte)
    );

    dft_byte_shifter #(.HALF_BIT(HALF_BIT)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sh_load),
        .byte_i (cur_byte),
        .done   (sh_done),
        .sclk   (ser_clk),
        .sdat   (ser_dat)
    );

    initial begin
        if (BYTE_SLOT < 16 * HALF_BIT + 2)
            $error("BYTE_SLOT too short for one byte");
    end

    AST_FNUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINISH) |=> (fnum_q == $past(fnum_q) + 8'd1)) else $error("frame number step"); // R2

    AST_SLOT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOAD && idx_q != '0) |-> (slot_q == SLOT_W'(BYTE_SLOT - 1))) else $error("byte slot period"); // R6

    AST_RELEASED_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_oe |-> !ser_clk) else $error("clock high while released"); // R7

    AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && state_q != S_FINISH) |=> (state_q != S_IDLE)) else $error("frame aborted"); // R9

    AST_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINISH) |-> (idx_q == IDX_W'(FRAME_BYTES - 1))) else $error("frame length"); // R11

endmodule

// File: tb/tb_dbg_frame_tx.sv
module tb_dbg_frame_tx;

    localparam int CLK_PERIOD = 10;
    localparam int HB = 1;
    localparam int BS = 20;
    localparam int OE_LEN = 29 * BS + 16 * HB + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_en = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  version_i = '0;
    logic [63:0] ref_i = '0, sig_i = '0, dlt_i = '0;
    logic [7:0]  flag0_i = '0, flag1_i = '0;
    logic        cal_i = 1'b0;
    logic [2:0]  nact_i = '0;
    logic [3:0]  touch_i = '0;
    logic        ser_clk, ser_dat, ser_oe;

    dbg_frame_tx #(.HALF_BIT(HB), .BYTE_SLOT(BS)) dut (
        .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .start(start),
        .version_i(version_i), .ref_i(ref_i), .sig_i(sig_i), .dlt_i(dlt_i),
        .flag0_i(flag0_i), .flag1_i(flag1_i), .cal_i(cal_i), .nact_i(nact_i),
        .touch_i(touch_i), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_oe(ser_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit summary_done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // receiver model
    int   cyc = 0, oe_len = 0, rx_n = 0, nbits = 0, last_start = 0;
    bit   frame_done = 0, p_clk = 0, p_dat = 0, p_oe = 0;
    logic [7:0] shreg;
    logic [7:0] rx [64];

    always @(negedge clk) begin
        cyc++;
        if (ser_oe) oe_len++;
        if (ser_oe && ser_clk && !p_clk) begin
            if (nbits == 0) begin
                if (rx_n > 0) chk(cyc - last_start == BS, "R6 byte spacing", cyc - last_start, BS);
                last_start = cyc;
            end
            shreg = {shreg[6:0], ser_dat};
            nbits++;
            if (nbits == 8) begin
                if (rx_n < 64) rx[rx_n] = shreg;
                rx_n++;
                nbits = 0;
            end
        end
        if (ser_clk && p_clk && ser_dat != p_dat)
            chk(0, "R7 data moved while clock high", ser_dat, p_dat);
        if (!ser_oe && ser_clk)
            chk(0, "R7 clock high while released", 1, 0);
        if (p_oe && !ser_oe) frame_done = 1;
        p_clk = ser_clk;
        p_dat = ser_dat;
        p_oe  = ser_oe;
    end

    // expected model
    logic [7:0] exp_b [30];
    logic [7:0] exp_fnum = 8'd0;

    function automatic logic [7:0] half16(input logic [63:0] bus, input int ch, input int hi);
        logic [15:0] w;
        w = bus[ch*16 +: 16];
        return hi ? w[15:8] : w[7:0];
    endfunction

    task automatic build_exp();
        exp_b[0] = exp_fnum;
        exp_b[1] = version_i;
        for (int i = 0; i < 8; i++) begin
            exp_b[2 + i]  = half16(ref_i, i / 2, i % 2);
            exp_b[10 + i] = half16(sig_i, i / 2, i % 2);
            exp_b[18 + i] = half16(dlt_i, i / 2, i % 2);
        end
        exp_b[26] = flag0_i;
        exp_b[27] = flag1_i;
        exp_b[28] = {cal_i, nact_i, touch_i};
        exp_b[29] = exp_fnum;
    endtask

    function automatic string req_of(input int i);
        if (i == 0 || i == 29) return "R2 frame number";
        if (i == 1) return "R3 version";
        if (i < 26) return "R4 channel value";
        return "R5 flags/status";
    endfunction

    task automatic rand_fields();
        version_i = 8'($urandom);
        ref_i = {$urandom, $urandom};
        sig_i = {$urandom, $urandom};
        dlt_i = {$urandom, $urandom};
        flag0_i = 8'($urandom);
        flag1_i = 8'($urandom);
        cal_i = 1'($urandom);
        nact_i = 3'($urandom);
        touch_i = 4'($urandom);
    endtask

    task automatic run_frame(input bit mutate, input bit midstart, input bit full);
        int waited;
        @(posedge clk);
        rx_n = 0; oe_len = 0; nbits = 0; frame_done = 0;
        @(negedge clk);
        dbg_en = 1'b1;
        start  = 1'b1;
        build_exp();
        @(negedge clk);
        start = 1'b0;
        if (mutate) begin
            repeat (3 * BS) @(negedge clk);
            rand_fields();  // R8: must not leak into this frame
        end
        if (midstart) begin
            repeat (5 * BS) @(negedge clk);
            start = 1'b1;   // R9: busy start
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!frame_done && waited < 4 * OE_LEN) begin
            @(negedge clk);
            waited++;
        end
        if (!frame_done) begin
            chk(0, "R11 frame never ended", waited, OE_LEN);
            return;
        end
        if (full) begin
            chk(rx_n == 30, "R11 byte count", rx_n, 30);
            chk(oe_len == OE_LEN, "R11 drive length", oe_len, OE_LEN);
            for (int i = 0; i < 30; i++)
                chk(rx[i] == exp_b[i], req_of(i), rx[i], exp_b[i]);
        end else begin
            chk(rx[0] == exp_fnum && rx[29] == exp_fnum, "R2 frame number wrap", rx[29], exp_fnum);
        end
        exp_fnum = exp_fnum + 8'd1;
        @(posedge clk);
        oe_len = 0;
        repeat (3 * BS) @(negedge clk);
        chk(oe_len == 0 && !ser_oe, "R9 R1 no extra frame after completion", oe_len, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!ser_oe && !ser_clk, "R1 reset lines released", {ser_oe, ser_clk}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!ser_oe, "R1 idle after reset", ser_oe, 0);

        // directed: extreme delta values, status packing
        ref_i = 64'h0001_FFFF_8000_1234;
        sig_i = 64'h03E8_0000_00FF_FF00;
        dlt_i = 64'h8000_7FFF_FFFF_0001;
        version_i = 8'h21; flag0_i = 8'hA5; flag1_i = 8'h5A;
        cal_i = 1'b1; nact_i = 3'd4; touch_i = 4'b1010;
        run_frame(0, 0, 1);

        // R10: start ignored while debug mode off
        @(posedge clk);
        oe_len = 0;
        @(negedge clk);
        dbg_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2 * BS) @(negedge clk);
        chk(oe_len == 0 && !ser_oe, "R10 disabled start ignored", oe_len, 0);

        // random frames with mutation and busy starts
        for (int f = 0; f < 6; f++) begin
            rand_fields();
            run_frame(f % 2 == 0, f % 3 == 1, 1);
        end

        // run the counter past its wrap
        while (exp_fnum != 8'd2 || n_chk < 300) begin
            rand_fields();
            run_frame(0, 0, exp_fnum >= 8'd254 || exp_fnum <= 8'd1);
        end

        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!summary_done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    end

endmodule